// File: doc/BRIEF.md
# Gated Parallel-Load Serial Shift Register

This block is an eight-stage register that either captures a whole parallel word or shifts by one position. It changes only on a rising clock edge, and its one data output is the last stage. When the active-low load select is asserted, a qualifying edge copies the parallel word into the stages. When the load select is deasserted, the same edge moves every stage one position toward the output and takes the serial input into the first stage. An active-low clock enable qualifies every edge. While the enable is high, neither a load nor a shift takes place and the contents stay as they are.

An active-low clear empties the register at once, without waiting for a clock. Because the register presents its highest stage on the output, a loaded word comes out most significant bit first. Connecting the output of one register to the serial input of another, with the clock, enable and load select shared, builds a longer register. A monitor output, `en_glitch`, reports a clock-enable protocol violation, which is described in R8.

Top module: `gated_piso`

## Requirements
- R1: When `load_n`=0 and `en_n`=0 at a rising edge, stage i takes `par_in[i]` for every i from 0 to 7.
- R2: When `load_n`=1 and `en_n`=0 at a rising edge, stage i+1 takes stage i for i from 0 to 6, and stage 0 takes `ser_in`.
- R3: When `en_n`=1 at a rising edge, all stages keep their values, whatever the levels on `load_n`, `ser_in` and `par_in`.
- R4: When `clr_n` goes low, all stages go to 0 at once, without a clock edge, so `ser_out` reads 0.
- R5: `ser_out` always shows stage 7. After a load, successive shifts therefore present bit 7, then bit 6, down to bit 0 of the loaded word.
- R6: The clear overrides any load or shift that is pending at the same edge. After `clr_n` returns high, the register holds 0 until the first rising edge that has `en_n`=0.
- R7: Two instances chained from `ser_out` to `ser_in`, with the clock, enable and load select shared, behave as one sixteen-stage register.
- R8: At each falling clock edge, `en_glitch` is set to 1 if `en_n` was 1 at the previous rising edge and is 0 at this falling edge, which means the enable fell while the clock was high. Otherwise it is set to 0. The clear forces it to 0.
- R9: Changes on the inputs between rising edges do not change `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | 0 = parallel load, 1 = serial shift |
| en_n | input | 1 | Clock enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Last stage (stage 7) |
| en_glitch | output | 1 | Enable protocol violation in the last high phase of the clock |

## Verification
The assertions assume that the clear is held across at least one rising edge and is released only while the clock is low, so that a disabled attempt never spans the release. They also assume that every control input is stable at each rising edge. To keep within these assumptions, the stimulus changes inputs only just after a falling edge. The one exception is a single deliberate enable drop during a high phase, which exercises R8. The assertions then treat the edge that follows that drop as an ordinary enabled shift.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } shreg_mode_e;
endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic        en_n,
    input  logic        load_n,
    output shreg_mode_e mode
);
    // The enable takes precedence: a disabled edge neither loads nor shifts.
    always_comb begin
        if (en_n)
            mode = MODE_HOLD;
        else if (!load_n)
            mode = MODE_LOAD;
        else
            mode = MODE_SHIFT;
    end
endmodule

// File: rtl/shreg_edge_mon.sv
module shreg_edge_mon (
    input  logic clk,
    input  logic clr_n,
    input  logic en_n,
    output logic en_glitch
);
    logic en_rise_d, en_rise_q;
    logic glitch_d,  glitch_q;

    always_comb begin
        en_rise_d = en_n;
        // Enable was high at the rising edge and is low now: it fell while clk was high.
        glitch_d  = en_rise_q & ~en_n;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) en_rise_q <= 1'b0;
        else        en_rise_q <= en_rise_d;
    end

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) glitch_q <= 1'b0;
        else        glitch_q <= glitch_d;
    end

    assign en_glitch = glitch_q;
endmodule

// File: rtl/gated_piso.sv
module gated_piso
    import shreg_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load_n,
    input  logic              en_n,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              ser_out,
    output logic              en_glitch
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stage;
    } shreg_state_t;

    shreg_state_t      state_d, state_q;
    shreg_mode_e       mode;
    logic [STAGES-1:0] shifted;

    shreg_mode_dec u_dec (
        .en_n   (en_n),
        .load_n (load_n),
        .mode   (mode)
    );

    shreg_edge_mon u_mon (
        .clk       (clk),
        .clr_n     (clr_n),
        .en_n      (en_n),
        .en_glitch (en_glitch)
    );

    // Shift source for each stage: stage 0 takes the serial input, the others take their neighbour.
    for (genvar i = 0; i < STAGES; i++) begin : g_shift
        if (i == 0) begin : g_head
            assign shifted[i] = ser_in;
        end else begin : g_body
            assign shifted[i] = state_q.stage[i-1];
        end
    end

    always_comb begin
        state_d = state_q;
        case (mode)
            MODE_LOAD:  state_d.stage = par_in;
            MODE_SHIFT: state_d.stage = shifted;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ser_out = state_q.stage[LAST];
endmodule

// File: rtl/gated_piso_chk.sv
module gated_piso_chk #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load_n,
    input  logic              en_n,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    input  logic [STAGES-1:0] stage,
    input  logic              ser_out
);
    // R1
    p_load_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_n && !load_n) |=> (stage == $past(par_in)));

    // R2
    p_shift_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_n && load_n) |=> (stage == {$past(stage[STAGES-2:0]), $past(ser_in)}));

    // R3
    p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
        en_n |=> $stable(stage));

    // R4
    p_clear_zero_r4: assert property (@(posedge clk)
        !clr_n |-> (ser_out == 1'b0));

    // R6: the first edge after the clear is released, if disabled, leaves the register empty.
    p_stay_clear_r6: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(!clr_n) && en_n) |=> (stage == '0));
endmodule

bind gated_piso gated_piso_chk #(.STAGES(STAGES)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .load_n  (load_n),
    .en_n    (en_n),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .stage   (state_q.stage),
    .ser_out (ser_out)
);

// File: tb/gated_piso_test.sv
module gated_piso_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_n = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = '0;
    logic [7:0] par_hi = '0;
    logic       ser_out, en_glitch;
    logic       out_hi, glitch_hi;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = '0;  // [7:0] = uut, [15:8] = uut_hi
    bit done = 0;

    always #10 clk = ~clk;

    gated_piso uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_n(en_n),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .en_glitch(en_glitch)
    );

    gated_piso uut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_n(en_n),
        .ser_in(ser_out), .par_in(par_hi), .ser_out(out_hi), .en_glitch(glitch_hi)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive after the falling edge, check stability, take the rising edge, check.
    task automatic step(input logic ld, input logic en, input logic s,
                        input logic [7:0] p, input logic [7:0] ph, input string req);
        @(negedge clk);
        load_n = ld; en_n = en; ser_in = s; par_in = p; par_hi = ph;
        #5;
        check("R9 no change between edges", ser_out, model[7]);
        @(posedge clk);
        if (!en) begin
            if (!ld) model = {ph, p};
            else     model = {model[14:0], s};
        end
        #5;
        check(req, ser_out, model[7]);
        check("R7 chained output", out_hi, model[15]);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Clear
        repeat (2) @(posedge clk);
        #5;
        check("R4 reset state", ser_out, 1'b0);
        check("R8 reset flag", en_glitch, 1'b0);
        @(negedge clk);
        clr_n = 1'b1;
        step(1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, "R6 stays clear while disabled");

        // Load, shift, inhibit, shift
        step(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, "R1 load shows bit 7");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, "R5 shift order");
        for (int k = 0; k < 3; k++) step(k[0], 1'b1, ~k[0], 8'hFF, 8'h00, "R3 inhibit holds");
        for (int k = 0; k < 13; k++) step(1'b1, 1'b0, k[1], 8'h00, 8'h00, "R2 shift serial in");

        // Sweep every parallel word: load, then eight shifts with a varying serial pattern
        for (int w = 0; w < 256; w++) begin
            step(1'b0, 1'b0, 1'b0, w[7:0], ~w[7:0], "R1 load sweep");
            for (int b = 0; b < 8; b++)
                step(1'b1, 1'b0, w[b] ^ b[0], 8'h00, 8'h00, "R5 sweep shift");
        end

        // Clear during a pending load, checked before any edge
        step(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, "R1 load ones");
        @(posedge clk);
        model = {model[15:8] == 8'hFF ? 8'hFF : model[15:8], 8'hFF};
        #3;
        clr_n = 1'b0;
        model = '0;
        #1;
        check("R4 immediate clear", ser_out, 1'b0);
        check("R4 immediate clear chained", out_hi, 1'b0);
        @(posedge clk);
        #5;
        check("R6 clear beats pending load", ser_out, 1'b0);
        @(negedge clk);
        clr_n = 1'b1;
        en_n = 1'b1;
        #5;
        check("R6 clear held after release", ser_out, 1'b0);
        step(1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, "R6 disabled edge after release");
        step(1'b0, 1'b0, 1'b0, 8'h80, 8'h01, "R6 first qualifying edge loads");

        // Enable protocol violation
        @(negedge clk);
        en_n = 1'b1; load_n = 1'b1; ser_in = 1'b1;
        @(posedge clk);
        #2;
        en_n = 1'b0;
        @(negedge clk);
        #2;
        check("R8 glitch flagged", en_glitch, 1'b1);
        @(posedge clk);
        model = {model[14:0], 1'b1};
        #5;
        check("R2 shift after glitch", ser_out, model[7]);
        @(negedge clk);
        #2;
        check("R8 glitch cleared", en_glitch, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R2 final shift");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule